// File: doc/BRIEF.md
# Packet Execution Time Limiter

This block sets the time budget for the program carried inside each arriving packet. It watches the line receive strobes and counts the clock cycles the packet takes to arrive, from its first cycle to its last. Enough of the packet must be buffered before the program can run. Once the configured number of data beats has arrived, the block raises a start pulse to the program processor.

From that start pulse, the program gets exactly as many cycles as the packet took to arrive. If the program has not signalled that it finished by then, the block issues a kill pulse that halts the processor. In the next cycle it issues a clear pulse, which wipes the per-packet registers and temporary memory and frees the input buffer.

The kill and clear pulses are not wired to the burst copy engine or to permanent memory, so an ongoing input-to-output copy and any stored state survive an expiry. A program that finishes in time ends the packet quietly, with neither pulse. While the block is busy with a packet it ignores any new packet start.

Top module: `exec_budget_guard`

## Requirements
- R1: After reset, execStart, execKill, resClear and busy are all low.
- R2: The receive duration L is the number of cycles from the cycle with pktStart through the cycle with pktEnd, both counted. A packet with pktStart and pktEnd in the same cycle has L = 1.
- R3: The beat count includes the pktStart cycle plus every later cycle with beatValid high, up to pktEnd. execStart pulses for one cycle, one cycle after the first cycle in which the registered beat count is at least threshold. A threshold of 0 acts as 1, so with continuous beats execStart comes max(threshold,1)+1 cycles after pktStart.
- R4: If pktEnd arrives before the threshold is reached, execStart pulses L+1 cycles after the pktStart cycle.
- R5: Without a finish, execKill pulses for one cycle exactly L cycles after the execStart cycle. At most one of execStart, execKill and resClear is high in any cycle.
- R6: resClear pulses for one cycle in the cycle after execKill. busy is high from the cycle after an accepted pktStart through the resClear cycle, and low in the cycle after it.
- R7: A finReq sampled while the program runs (execStart cycle through L-1 cycles after it) makes busy low in the next cycle, and neither execKill nor resClear occurs. This holds even when finReq comes in the last budget cycle.
- R8: finReq has no effect while the block is idle or still waiting for the threshold.
- R9: pktStart while busy is high is ignored: no extra execStart, and the current packet's timing is unchanged.
- R10: execKill never occurs before the receive duration is final, that is, before pktEnd has been sampled.
- R11: Cycles with beatValid low add to L but not to the beat count, so gaps in the data delay execStart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pktStart | input | 1 | First cycle of a packet, carries a data beat |
| beatValid | input | 1 | A data beat is written to the input buffer this cycle |
| pktEnd | input | 1 | Last cycle of the packet |
| threshold | input | CNT_W | Beats needed before execution may begin |
| finReq | input | 1 | Program reports it has finished |
| execStart | output | 1 | One-cycle pulse: program may begin |
| execKill | output | 1 | One-cycle pulse: halt the program now |
| resClear | output | 1 | One-cycle pulse: wipe registers and temporary memory, free input buffer |
| busy | output | 1 | A packet is being handled |

## Verification
The assertions assume a well-formed receive stream. pktStart comes only from an idle line, and each packet has exactly one pktEnd, at or after its start. threshold stays stable for the whole packet. Packets are shorter than the counter range, so the saturating counters never reach their limit.

The stimulus keeps to these rules by driving whole packets from one task, holding threshold constant per packet and spacing packets apart. The single deliberate pktStart during busy is placed after the current packet's pktEnd, so it tests only the rule that such a start is ignored.

// File: rtl/exec_budget_pkg.sv
package exec_budget_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic newPkt;   // load counters for a fresh packet
    logic track;    // keep measuring the receive side
    logic runLoad;  // execution starts: elapsed count to 1
    logic runInc;   // execution continues: elapsed count up
  } ctl_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_BUF  = 3'd1,
    S_RUN  = 3'd2,
    S_KILL = 3'd3,
    S_CLR  = 3'd4
  } state_t;
endpackage

// File: rtl/exec_budget_dp.sv
module exec_budget_dp
  import exec_budget_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_t             ctl,
  input  logic             beatValid,
  input  logic             pktEnd,
  input  logic [CNT_W-1:0] threshold,
  output logic             rxFinal,
  output logic             startReady,
  output logic             expired
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] rxCnt;
  logic [CNT_W-1:0] beatCnt;
  logic [CNT_W-1:0] exCnt;
  logic             rxDone;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxCnt   <= '0;
      beatCnt <= '0;
      rxDone  <= 1'b0;
    end else if (ctl.newPkt) begin
      rxCnt   <= {{(CNT_W-1){1'b0}}, 1'b1};
      beatCnt <= {{(CNT_W-1){1'b0}}, 1'b1};
      rxDone  <= pktEnd;
    end else if (ctl.track && !rxDone) begin
      if (rxCnt != CNT_MAX) rxCnt <= rxCnt + 1'b1;
      if (beatValid && beatCnt != CNT_MAX) beatCnt <= beatCnt + 1'b1;
      if (pktEnd) rxDone <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exCnt <= '0;
    end else if (ctl.runLoad) begin
      exCnt <= {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (ctl.runInc && exCnt != CNT_MAX) begin
      exCnt <= exCnt + 1'b1;
    end
  end

  assign rxFinal    = rxDone;
  assign startReady = rxDone || (beatCnt >= threshold);
  assign expired    = rxDone && (exCnt >= rxCnt);

  // R2
  rx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxDone && !ctl.newPkt) |=> $stable(rxCnt));
endmodule

// File: rtl/exec_budget_ctl.sv
module exec_budget_ctl
  import exec_budget_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pktStart,
  input  logic finReq,
  input  logic rxFinal,
  input  logic startReady,
  input  logic expired,
  output ctl_t ctl,
  output logic execStart,
  output logic execKill,
  output logic resClear,
  output logic busy
);
  state_t state, nxt;
  logic   startPulse;

  always_comb begin
    nxt = state;
    ctl = '0;
    case (state)
      S_IDLE: if (pktStart) begin
        ctl.newPkt = 1'b1;
        nxt        = S_BUF;
      end
      S_BUF: begin
        ctl.track = 1'b1;
        if (startReady) begin
          ctl.runLoad = 1'b1;
          nxt         = S_RUN;
        end
      end
      S_RUN: begin
        ctl.track = 1'b1;
        if (finReq)       nxt = S_IDLE;
        else if (expired) nxt = S_KILL;
        else              ctl.runInc = 1'b1;
      end
      S_KILL:  nxt = S_CLR;
      S_CLR:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      startPulse <= 1'b0;
    end else begin
      state      <= nxt;
      startPulse <= (state == S_BUF) && startReady;
    end
  end

  assign execStart = startPulse;
  assign execKill  = (state == S_KILL);
  assign resClear  = (state == S_CLR);
  assign busy      = (state != S_IDLE);

  // R6
  kill_then_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    execKill |=> (resClear && busy));
  // R6
  clear_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resClear |=> !busy);
  // R5
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({execStart, execKill, resClear}));
  // R10
  kill_after_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_RUN) && !rxFinal) |=> !execKill);
  // R7
  fin_no_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_RUN) && finReq) |=> (!busy && !execKill));
endmodule

// File: rtl/exec_budget_guard.sv
module exec_budget_guard
  import exec_budget_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pktStart,
  input  logic             beatValid,
  input  logic             pktEnd,
  input  logic [CNT_W-1:0] threshold,
  input  logic             finReq,
  output logic             execStart,
  output logic             execKill,
  output logic             resClear,
  output logic             busy
);
  ctl_t ctl;
  logic rxFinal, startReady, expired;

  exec_budget_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pktStart   (pktStart),
    .finReq     (finReq),
    .rxFinal    (rxFinal),
    .startReady (startReady),
    .expired    (expired),
    .ctl        (ctl),
    .execStart  (execStart),
    .execKill   (execKill),
    .resClear   (resClear),
    .busy       (busy)
  );

  exec_budget_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .beatValid  (beatValid),
    .pktEnd     (pktEnd),
    .threshold  (threshold),
    .rxFinal    (rxFinal),
    .startReady (startReady),
    .expired    (expired)
  );
endmodule

// File: tb/exec_budget_guard_tb.sv
module exec_budget_guard_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pktStart = 1'b0, beatValid = 1'b0, pktEnd = 1'b0, finReq = 1'b0;
  logic [CNT_W-1:0] threshold = '0;
  logic execStart, execKill, resClear, busy;

  exec_budget_guard #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pktStart(pktStart), .beatValid(beatValid),
    .pktEnd(pktEnd), .threshold(threshold), .finReq(finReq),
    .execStart(execStart), .execKill(execKill), .resClear(resClear), .busy(busy)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nRun = 0, nFail = 0;
  int tStart, tKill, tClr, nStart, nKill, nClr;

  always @(negedge clk) begin
    if (execStart) begin tStart = cyc; nStart++; end
    if (execKill)  begin tKill  = cyc; nKill++;  end
    if (resClear)  begin tClr   = cyc; nClr++;   end
  end

  // vector table: length, threshold, finish offset from start (-1 none)
  localparam int VN = 7;
  localparam int VLEN[VN] = '{4, 6, 3, 10, 1, 5, 5};
  localparam int VTHR[VN] = '{2, 1, 9, 4, 1, 0, 2};
  localparam int VFIN[VN] = '{-1, -1, -1, 3, -1, -1, 4};

  task automatic chk(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic toCycle(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic sendPkt(int len, bit gaps);
    for (int i = 0; i < len; i++) begin
      pktStart  = (i == 0);
      beatValid = gaps ? (i % 2 == 0) : 1'b1;
      pktEnd    = (i == len - 1);
      @(negedge clk);
    end
    pktStart = 1'b0; beatValid = 1'b0; pktEnd = 1'b0;
  endtask

  task automatic pulseFin(int n);
    toCycle(n);
    finReq = 1'b1;
    @(negedge clk);
    finReq = 1'b0;
  endtask

  task automatic pulseStart(int n);
    toCycle(n);
    pktStart = 1'b1;
    @(negedge clk);
    pktStart = 1'b0;
  endtask

  task automatic clearStamps();
    tStart = -1; tKill = -1; tClr = -1;
    nStart = 0; nKill = 0; nClr = 0;
  endtask

  // run one packet with continuous beats; fin offset f (-1 none); extra start offset x (-1 none)
  task automatic runPkt(string tag, int len, int thr, int f, bit gaps, int expS, int xs);
    int t0;
    int budgetEnd;
    @(negedge clk);
    clearStamps();
    threshold = CNT_W'(thr);
    t0 = cyc;
    fork
      sendPkt(len, gaps);
      if (f >= 0) pulseFin(t0 + expS + f);
      if (xs >= 0) pulseStart(t0 + expS + xs);
      begin toCycle(t0 + 1); chk({tag, " R6 busy after start"}, int'(busy), 1); end
    join
    toCycle(t0 + expS + len + 8);
    chk({tag, " R3 R4 R11 start cycle"}, tStart - t0, expS);
    chk({tag, " R9 start count"}, nStart, 1);
    if (f >= 0) begin
      chk({tag, " R7 no kill"}, nKill, 0);
      chk({tag, " R7 no clear"}, nClr, 0);
    end else begin
      budgetEnd = tStart + len;
      chk({tag, " R2 R5 R10 kill cycle"}, tKill, budgetEnd);
      chk({tag, " R6 clear cycle"}, tClr, budgetEnd + 1);
      chk({tag, " R5 kill count"}, nKill, 1);
    end
    chk({tag, " R6 idle at end"}, int'(busy), 0);
  endtask

  task automatic checkIdleAt(string tag, int n);
    toCycle(n);
    chk(tag, int'(busy), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    clearStamps();
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    chk("R1 start in reset", int'(execStart), 0);
    chk("R1 kill in reset", int'(execKill), 0);
    chk("R1 clear in reset", int'(resClear), 0);
    chk("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);

    for (int v = 0; v < VN; v++) begin
      int eff, expS;
      eff  = (VTHR[v] < 1) ? 1 : VTHR[v];
      expS = ((eff < VLEN[v]) ? eff : VLEN[v]) + 1;
      runPkt($sformatf("vec%0d", v), VLEN[v], VTHR[v], VFIN[v], 1'b0, expS, -1);
      repeat (3) @(negedge clk);
    end

    // R7 busy falls one cycle after finish
    begin
      int t0;
      @(negedge clk);
      clearStamps();
      threshold = CNT_W'(2);
      t0 = cyc;
      fork
        sendPkt(8, 1'b0);
        pulseFin(t0 + 3 + 2);
        begin toCycle(t0 + 3 + 2); chk("R7 busy in fin cycle", int'(busy), 1); end
        checkIdleAt("R7 idle after fin", t0 + 3 + 3);
      join
      repeat (12) @(negedge clk);
      chk("R7 no kill after fin", nKill, 0);
    end

    // R8 finish while waiting for threshold is ignored
    begin
      int t0;
      @(negedge clk);
      clearStamps();
      threshold = CNT_W'(5);
      t0 = cyc;
      fork
        sendPkt(6, 1'b0);
        pulseFin(t0 + 2);
      join
      toCycle(t0 + 30);
      chk("R8 start despite early fin", tStart - t0, 6);
      chk("R8 kill despite early fin", tKill - t0, 12);
    end

    // R8 finish while idle is ignored
    begin
      @(negedge clk);
      clearStamps();
      finReq = 1'b1;
      repeat (2) @(negedge clk);
      finReq = 1'b0;
      chk("R8 idle fin busy", int'(busy), 0);
      chk("R8 idle fin no pulse", nStart + nKill + nClr, 0);
    end

    // R9 start while busy ignored (after this packet's end)
    runPkt("R9 busy start", 4, 1, -1, 1'b0, 2, 2);
    repeat (3) @(negedge clk);

    // R11 gaps: beats on every other cycle, threshold 3 reached at T+5
    runPkt("R11 gaps", 8, 3, -1, 1'b1, 6, -1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule